// File: doc/BRIEF.md
# Configuration Memory CRC Error Monitor

This block watches a small on-chip configuration memory for silent corruption. It reads the memory one 32-bit word per clock, from the lowest address to the highest, and wraps around without stopping. Over each full sweep it builds a 32-bit CRC. A reference register holds the CRC that the contents should produce. While the chip is still being configured, the reference register follows the sweep result. Once the chip is in user mode, every sweep result is compared with the reference, and a mismatch raises an error flag.

The reference register can also be reached through a simplified test-access path. When a dedicated 10-bit instruction is loaded and the chip is in user mode, the register can be captured, shifted out on `tdo` and reloaded from `tdi`. Software can use this path to load a deliberately wrong reference, see the flag rise, and then put the right value back to clear it, all without a reset. The TAP state machine itself sits outside this block. Its capture, shift and update phases arrive here as one-cycle strobes that are synchronous to `clk`.

Top module: `cramCrcMonitor`

## Requirements
- R1: After reset `rdAddr` is 0. It then increases by one on every clock, and from DEPTH-1 it wraps to 0.
- R2: `passDone` is high for exactly one cycle, in the cycle after the word at address DEPTH-1 has been consumed, so it pulses once every DEPTH cycles.
- R3: The sweep CRC is the reflected CRC-32: generator 0x04C11DB7 (bit-reversed form 0xEDB88320), starting value all ones, result inverted. Each word is fed least significant bit first, starting at address 0.
- R4: When `userMode` is 0 at the end of a sweep, the reference register takes that sweep's CRC and `crcErr` is driven to 0.
- R5: When `userMode` is 1 at the end of a sweep, `crcErr` is set to whether the sweep's CRC differs from the reference. It holds that value until the next sweep ends.
- R6: With `tapInstr` equal to 10'b00_0001_0101 and `userMode` 1, `captureDr` copies the reference into the shift register. Each `shiftDr` cycle moves that register one bit toward `tdo`: `tdo` shows bit 0, and `tdi` enters at bit 31.
- R7: With the same instruction and mode, `updateDr` loads the shift register into the reference. Capturing and shifting without an update leave the reference unchanged.
- R8: With any other instruction, or with `userMode` 0, the TAP strobes leave the reference untouched and `tdo` stays 0.
- R9: Loading a wrong reference through the TAP makes `crcErr` rise at the next sweep end. Loading the correct value back clears it at the sweep end after that. No reset is involved.
- R10: A single bit flipped in the memory during user mode raises `crcErr` by the second sweep end after the flip.
- R11: While reset is held, `crcErr`, `passDone` and `tdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr | output | ADDR_W | Memory read address |
| rdData | input | DATA_W | Memory read data for `rdAddr`, same cycle |
| userMode | input | 1 | 1 = user mode, 0 = configuration |
| tapInstr | input | 10 | Current TAP instruction register contents |
| captureDr | input | 1 | Capture-DR strobe |
| shiftDr | input | 1 | Shift-DR strobe, one bit per cycle |
| updateDr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| crcErr | output | 1 | Registered mismatch flag |
| passDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
`crcErr` and `passDone` both change on the same clock edge: the one that consumes the word at address DEPTH-1. For this reason the bench waits for a falling edge at which `passDone` is high and reads `crcErr` right there. A change to the reference or to the memory can land in the middle of a sweep. After a TAP update the bench therefore checks at the first `passDone`, and after a memory flip it checks at the second, because the flipped word may already have been read in the current sweep. `tdo` is combinational from the shift register, so each bit is read on the falling edge before the shift edge that moves it out.

// File: rtl/crcmon_pkg.sv
package crcmon_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;
  localparam int IR_W = 10;
  localparam logic [IR_W-1:0] IR_REF_ACCESS = 10'b00_0001_0101;

  typedef struct packed {
    logic lastWord;
    logic latchRef;
    logic compare;
    logic tapSel;
    logic capture;
    logic shift;
    logic update;
  } monStrobes_t;

  function automatic logic [CRC_W-1:0] crcFeed(input logic [CRC_W-1:0] c,
                                               input logic [CRC_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < CRC_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/crcmon_ctrl.sv
module crcmon_ctrl
  import crcmon_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userMode,
  input  logic [IR_W-1:0]   tapInstr,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              passDone,
  output monStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic atLast;
  logic tapSel;

  assign atLast = (rdAddr == LAST_ADDR);
  assign tapSel = userMode && (tapInstr == IR_REF_ACCESS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr   <= '0;
      passDone <= 1'b0;
    end else begin
      rdAddr   <= atLast ? '0 : rdAddr + 1'b1;
      passDone <= atLast;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.lastWord = atLast;
    strobes.latchRef = atLast && !userMode;
    strobes.compare  = atLast && userMode;
    strobes.tapSel   = tapSel;
    strobes.capture  = tapSel && captureDr;
    strobes.shift    = tapSel && shiftDr;
    strobes.update   = tapSel && updateDr;
  end
endmodule

// File: rtl/crcmon_dp.sv
module crcmon_dp
  import crcmon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobes_t       strobes,
  input  logic [DATA_W-1:0] rdData,
  input  logic              tdi,
  output logic              tdo,
  output logic              crcErr
);
  logic [CRC_W-1:0] crcAcc;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] passCrc;
  logic [CRC_W-1:0] refCrc;
  logic [CRC_W-1:0] shReg;
  logic [CRC_W-1:0] wordIn;

  generate
    if (DATA_W >= CRC_W) begin : g_wide
      assign wordIn = rdData[CRC_W-1:0];
    end else begin : g_narrow
      assign wordIn = {{(CRC_W-DATA_W){1'b0}}, rdData};
    end
  endgenerate

  assign crcNext = crcFeed(crcAcc, wordIn);
  assign passCrc = ~crcNext;
  assign tdo     = strobes.tapSel ? shReg[0] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcAcc <= CRC_INIT;
    else       crcAcc <= strobes.lastWord ? CRC_INIT : crcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 refCrc <= '0;
    else if (strobes.latchRef) refCrc <= passCrc;
    else if (strobes.update)   refCrc <= shReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 crcErr <= 1'b0;
    else if (strobes.compare)  crcErr <= (passCrc != refCrc);
    else if (strobes.latchRef) crcErr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shReg <= '0;
    else if (strobes.capture) shReg <= refCrc;
    else if (strobes.shift)   shReg <= {tdi, shReg[CRC_W-1:1]};
  end
endmodule

// File: rtl/cramCrcMonitor.sv
module cramCrcMonitor
  import crcmon_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              userMode,
  input  logic [IR_W-1:0]   tapInstr,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic              crcErr,
  output logic              passDone
);
  monStrobes_t strobes;

  crcmon_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .userMode(userMode), .tapInstr(tapInstr),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .rdAddr(rdAddr), .passDone(passDone), .strobes(strobes)
  );

  crcmon_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(rdData),
    .tdi(tdi), .tdo(tdo), .crcErr(crcErr)
  );
endmodule

// File: rtl/crcmon_checker.sv
module crcmon_checker
  import crcmon_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              userMode,
  input logic [IR_W-1:0]   tapInstr,
  input logic              updateDr,
  input logic              crcErr,
  input logic              passDone,
  input logic              tdo,
  input logic [CRC_W-1:0]  refCrc
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr != LAST_ADDR) |=> (rdAddr == $past(rdAddr) + 1'b1));

  p_done_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> (rdAddr == '0 && $past(rdAddr) == LAST_ADDR));

  p_err_cfg_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (passDone && !$past(userMode)) |-> !crcErr);

  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !passDone |-> $stable(crcErr));

  p_ref_guard_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(refCrc) |->
      ($past(updateDr && userMode && tapInstr == IR_REF_ACCESS) ||
       (passDone && !$past(userMode))));

  always_comb begin
    if (!rstN) begin
      a_reset_quiet_r11: assert (!crcErr && !passDone && !tdo);
    end
  end
endmodule

bind cramCrcMonitor crcmon_checker #(.DEPTH(DEPTH)) u_crcmon_checker (
  .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .userMode(userMode),
  .tapInstr(tapInstr), .updateDr(updateDr), .crcErr(crcErr),
  .passDone(passDone), .tdo(tdo), .refCrc(i_dp.refCrc)
);

// File: tb/test_cramCrcMonitor.sv
module test_cramCrcMonitor;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [9:0] CODE = 10'b00_0001_0101;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic              userMode = 1'b0;
  logic [9:0]        tapInstr = '0;
  logic              captureDr = 1'b0;
  logic              shiftDr = 1'b0;
  logic              updateDr = 1'b0;
  logic              tdi = 1'b0;
  logic              tdo;
  logic              crcErr;
  logic              passDone;
  logic [31:0]       mem [DEPTH];
  int                nTests = 0;
  int                nFail = 0;

  always #2.5 clk = ~clk;
  assign rdData = mem[rdAddr];

  cramCrcMonitor #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_cramCrcMonitor (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData),
    .userMode(userMode), .tapInstr(tapInstr), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .crcErr(crcErr), .passDone(passDone)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrcOf();
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = 0; w < DEPTH; w++) begin
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, mem[w][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic fillMem(input logic [31:0] seed);
    for (int i = 0; i < DEPTH; i++) mem[i] = seed * (i + 3) ^ {i[7:0], 24'h5A3C1};
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!passDone);
  endtask

  // capture, shift 32 bits (tdi = inVal), optionally update; returns bits seen on tdo
  task automatic tapAccess(input logic [9:0] instr, input logic [31:0] inVal,
                           input logic doUpdate, output logic [31:0] outVal);
    tapInstr = instr;
    captureDr = 1'b1;
    @(negedge clk);
    captureDr = 1'b0;
    for (int i = 0; i < 32; i++) begin
      shiftDr = 1'b1;
      tdi = inVal[i];
      outVal[i] = tdo;
      @(negedge clk);
    end
    shiftDr = 1'b0;
    if (doUpdate) begin
      updateDr = 1'b1;
      @(negedge clk);
      updateDr = 1'b0;
    end
  endtask

  task automatic testReset();
    #1;
    check("R11 crcErr in reset", crcErr, 0);
    check("R11 passDone in reset", passDone, 0);
    check("R11 tdo in reset", tdo, 0);
    check("R1 rdAddr in reset", rdAddr, 0);
  endtask

  task automatic testScan();
    int doneCnt = 0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      check("R1 address sequence", rdAddr, (i % DEPTH));
      if (passDone) begin
        doneCnt++;
        check("R2 done after last word", rdAddr, 0);
      end
      @(negedge clk);
    end
    check("R2 one pulse per sweep", doneCnt, 1);
  endtask

  task automatic testConfigLatch(input logic [31:0] seed);
    logic [31:0] got;
    userMode = 1'b0;
    fillMem(seed);
    waitDone();
    waitDone();
    check("R4 err low in config", crcErr, 0);
    userMode = 1'b1;
    tapAccess(CODE, 32'h0, 1'b0, got);
    check("R3 reference equals CRC-32 of memory", got, refCrcOf());
    waitDone();
    check("R5 match gives no error", crcErr, 0);
    tapAccess(CODE, 32'hDEADBEEF, 1'b0, got);
    waitDone();
    check("R7 shift without update leaves reference", crcErr, 0);
  endtask

  task automatic testWrongRestore();
    logic [31:0] good = refCrcOf();
    logic [31:0] got;
    tapAccess(CODE, good ^ 32'h1, 1'b1, got);
    check("R6 tdo shows stored value", got, good);
    waitDone();
    check("R9 wrong reference raises error", crcErr, 1);
    repeat (DEPTH / 2) @(negedge clk);
    check("R5 error held mid-sweep", crcErr, 1);
    tapAccess(CODE, good, 1'b1, got);
    check("R7 updated reference read back", got, good ^ 32'h1);
    waitDone();
    check("R9 restored reference clears error", crcErr, 0);
  endtask

  task automatic testIgnored();
    logic [31:0] got;
    tapAccess(10'h3FF, 32'h12345678, 1'b1, got);
    check("R8 tdo quiet with other instruction", got, 0);
    waitDone();
    check("R8 other instruction no effect on error", crcErr, 0);
    tapAccess(CODE, 32'h0, 1'b0, got);
    check("R8 reference untouched", got, refCrcOf());
    userMode = 1'b0;
    tapAccess(CODE, 32'hA5A5A5A5, 1'b1, got);
    check("R8 tdo quiet in config mode", got, 0);
    userMode = 1'b1;
    waitDone();
  endtask

  task automatic testBitFlip();
    mem[DEPTH / 3] = mem[DEPTH / 3] ^ 32'h0000_0400;
    waitDone();
    waitDone();
    check("R10 bit flip raises error", crcErr, 1);
    mem[DEPTH / 3] = mem[DEPTH / 3] ^ 32'h0000_0400;
    waitDone();
    waitDone();
    check("R10 restored memory clears error", crcErr, 0);
  endtask

  initial begin
    fillMem(32'h1357_9BDF);
    testReset();
    testScan();
    testConfigLatch(32'h0BAD_F00D);
    testWrongRestore();
    testIgnored();
    testBitFlip();
    testConfigLatch(32'h7F00_00C1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #200000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule